// File: doc/BRIEF.md
# I2C Interrupt Status Flag Register

This block is the event-status register of an I2C controller. The protocol engine reports things that happen on the bus as one-cycle strobes: a byte sent or received, an address match, a NACK, START and STOP conditions, a finished byte count, and several error conditions. The block turns each strobe into a sticky flag. Software reads all flags as one 32-bit word. It clears most of them through a separate write-one-to-clear command, and it may set two transmit bits directly. Each flag has its own set and clear rule. The transmit-empty bit is set after reset and is held at 1 while the peripheral is disabled. One transmit-request write takes effect only in no-stretch mode. The two completion flags depend on the reload and auto-end settings. Clearing the peripheral enable wipes every flag at once.

On an address match the block also captures the transfer direction and a 7-bit address code, and holds them until the next match. A build parameter removes the three SMBus-only flags.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset the status word reads 0x00000001. Bit 0 is transmit-empty and is the only bit set.
- R2: Bit 0 (transmit-empty) sets on the tx-empty strobe or on a direct write with data bit 0 = 1 (a flush). It clears on the tx-load strobe. When a set and a clear arrive together, the set wins.
- R3: Bit 1 (transmit-request) sets on the tx-request strobe. A direct write with data bit 1 = 1 also sets it, but only while no_stretch = 1; otherwise that write is ignored. The bit clears on the tx-load strobe.
- R4: Bit 2 (receive-not-empty) sets on the rx-full strobe and clears on the rx-read strobe.
- R5: Bit 3 (address-match) sets on the address-match strobe, and it is cleared only by a clear command with data bit 3 = 1. Bit 16 (direction) and bits 23:17 (address code) load from their inputs on an address-match strobe and hold at all other times.
- R6: Bits 4 (NACK), 5 (stop), 8 (bus error), 9 (arbitration lost) and 10 (overrun) set on their strobes. A clear command with a 1 in the same bit position clears each one. A set strobe in the same cycle as a clear wins.
- R7: Bit 6 (transfer-complete) sets when the count-done strobe arrives with reload = 0 and auto_end = 0, and does not set otherwise. It clears when the start/stop request strobe pulses.
- R8: Bit 7 (transfer-complete-reload) sets when the count-done strobe arrives with reload = 1. It clears on the non-zero-count-write strobe.
- R9: Bit 15 (busy) sets on a detected START and clears on a detected STOP.
- R10: While periph_en = 0, bits 15:1 read 0 and bit 0 reads 1, and all strobes are ignored. Direction and address code keep their values.
- R11: Bits 11 (PEC error) and 12 (timeout) set on their strobes and clear through the clear command at the same bit position.
- R12: Bit 13 (alert) sets on a falling edge of alert_n only when host_mode = 1 and alert_en = 1. A level held low does not set it again after it is cleared.
- R13: When SMBUS_EN = 0, bits 11, 12 and 13 always read 0.
- R14: Clear-command bits outside {3,4,5,8..13} are ignored. Direct-write bits above bit 1 are ignored. Bits 14 and 31:24 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable level |
| no_stretch | input | 1 | Clock-stretching disabled level |
| reload | input | 1 | Byte-count reload mode level |
| auto_end | input | 1 | Automatic STOP after count level |
| host_mode | input | 1 | SMBus host configuration level |
| alert_en | input | 1 | Alert detection enable level |
| alert_n | input | 1 | Alert line, active low |
| ev_tx_empty | input | 1 | Transmit data register emptied |
| ev_tx_req | input | 1 | Engine requests next transmit byte |
| ev_tx_load | input | 1 | Software wrote transmit data |
| ev_rx_full | input | 1 | Received byte copied to receive register |
| ev_rx_read | input | 1 | Software read receive register |
| ev_addr_match | input | 1 | Own address matched |
| addr_dir | input | 1 | Direction seen with the address |
| addr_code | input | CODE_W | Matched address code |
| ev_nack | input | 1 | NACK received |
| ev_stop | input | 1 | STOP seen on an involved transfer |
| ev_count_done | input | 1 | Programmed byte count finished |
| ev_bus_err | input | 1 | Misplaced START or STOP |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_overrun | input | 1 | Overrun or underrun |
| ev_pec_err | input | 1 | PEC mismatch |
| ev_timeout | input | 1 | Bus timeout |
| bus_start | input | 1 | START condition detected |
| bus_stop | input | 1 | STOP condition detected |
| sw_start_stop | input | 1 | Software set start or stop request |
| sw_count_nz | input | 1 | Software wrote a non-zero byte count |
| clr_wr | input | 1 | Clear-command write strobe |
| clr_data | input | REG_W | Clear-command data, 1 clears |
| st_wr | input | 1 | Direct status write strobe |
| st_data | input | REG_W | Direct status write data |
| status | output | REG_W | Status word |

## Verification
The bench builds two instances side by side from the same stimulus. Instance u0 has SMBUS_EN = 1, so the PEC, timeout and alert paths are reachable. Instance u1 has SMBUS_EN = 0, so every cycle also shows that those three bits stay 0 (R13) whatever the strobes and the alert line do. Both use the default 7-bit code and 32-bit word. With these parameters, a sparse code value can be captured and then shown to stay unchanged through later non-match cycles and through a disable.

// File: rtl/i2c_sts_pkg.sv
package i2c_sts_pkg;
    localparam int FLAG_W  = 16;
    localparam int B_TXE   = 0;
    localparam int B_TXREQ = 1;
    localparam int B_RXNE  = 2;
    localparam int B_ADDR  = 3;
    localparam int B_NACK  = 4;
    localparam int B_STOP  = 5;
    localparam int B_TC    = 6;
    localparam int B_TCR   = 7;
    localparam int B_BERR  = 8;
    localparam int B_ARLO  = 9;
    localparam int B_OVR   = 10;
    localparam int B_PEC   = 11;
    localparam int B_TMO   = 12;
    localparam int B_ALERT = 13;
    localparam int B_BUSY  = 15;

    // positions a clear command may touch
    localparam logic [FLAG_W-1:0] W1C_MASK = 16'h3F38;
    // positions that exist only with the SMBus option
    localparam logic [FLAG_W-1:0] SMB_MASK = 16'h3800;
    localparam logic [FLAG_W-1:0] OFF_VAL  = 16'h0001;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } bank_st_t;

    typedef struct packed {
        logic dir;
        logic [6:0] code;
    } cap_st_t;
endpackage

// File: rtl/i2c_alert_edge.sv
module i2c_alert_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_n,
    output logic fall_o
);
    logic level_d, level_q;

    always_comb begin
        level_d = alert_n;
        fall_o  = level_q & ~alert_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_d;
    end
endmodule

// File: rtl/i2c_addr_capture.sv
module i2c_addr_capture #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              ev_addr_match,
    input  logic              addr_dir,
    input  logic [CODE_W-1:0] addr_code,
    output logic              dir_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic              dir;
        logic [CODE_W-1:0] code;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (periph_en && ev_addr_match) begin
            cap_d.dir  = addr_dir;
            cap_d.code = addr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dir_o  = cap_q.dir;
    assign code_o = cap_q.code;

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(periph_en && ev_addr_match) |=> $stable({dir_o, code_o}));
    // R5
    code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && ev_addr_match) |=> (code_o == $past(addr_code) && dir_o == $past(addr_dir)));
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
    import i2c_sts_pkg::*;
#(
    parameter bit SMBUS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              no_stretch,
    input  logic              reload,
    input  logic              auto_end,
    input  logic              host_mode,
    input  logic              alert_en,
    input  logic              alert_fall,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_req,
    input  logic              ev_tx_load,
    input  logic              ev_rx_full,
    input  logic              ev_rx_read,
    input  logic              ev_addr_match,
    input  logic              ev_nack,
    input  logic              ev_stop,
    input  logic              ev_count_done,
    input  logic              ev_bus_err,
    input  logic              ev_arb_lost,
    input  logic              ev_overrun,
    input  logic              ev_pec_err,
    input  logic              ev_timeout,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sw_start_stop,
    input  logic              sw_count_nz,
    input  logic              clr_wr,
    input  logic [FLAG_W-1:0] clr_bits,
    input  logic              st_wr,
    input  logic [1:0]        st_bits,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [FLAG_W-1:0] IMPL_MASK =
        SMBUS_EN ? ~16'h4000 : ~(16'h4000 | SMB_MASK);

    bank_st_t st_d, st_q;
    logic [FLAG_W-1:0] set_v, clr_v;
    logic flush, sw_req;

    always_comb begin
        flush  = st_wr & st_bits[0];
        sw_req = st_wr & st_bits[1] & no_stretch;

        set_v = '0;
        set_v[B_TXE]   = ev_tx_empty | flush;
        set_v[B_TXREQ] = ev_tx_req | sw_req;
        set_v[B_RXNE]  = ev_rx_full;
        set_v[B_ADDR]  = ev_addr_match;
        set_v[B_NACK]  = ev_nack;
        set_v[B_STOP]  = ev_stop;
        set_v[B_TC]    = ev_count_done & ~reload & ~auto_end;
        set_v[B_TCR]   = ev_count_done & reload;
        set_v[B_BERR]  = ev_bus_err;
        set_v[B_ARLO]  = ev_arb_lost;
        set_v[B_OVR]   = ev_overrun;
        set_v[B_PEC]   = ev_pec_err;
        set_v[B_TMO]   = ev_timeout;
        set_v[B_ALERT] = alert_fall & host_mode & alert_en;
        set_v[B_BUSY]  = bus_start;
        set_v = set_v & IMPL_MASK;

        clr_v = clr_wr ? (clr_bits & W1C_MASK) : '0;
        clr_v[B_TXE]   = ev_tx_load;
        clr_v[B_TXREQ] = ev_tx_load;
        clr_v[B_RXNE]  = ev_rx_read;
        clr_v[B_TC]    = sw_start_stop;
        clr_v[B_TCR]   = sw_count_nz;
        clr_v[B_BUSY]  = bus_stop;

        if (periph_en) st_d.flags = (st_q.flags & ~clr_v) | set_v;
        else           st_d.flags = OFF_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.flags <= OFF_VAL;
        else        st_q       <= st_d;
    end

    assign flags_o = st_q.flags;

    // R10
    off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (flags_o == 16'h0001));
    // R4
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && ev_rx_full) |=> flags_o[B_RXNE]);
    // R2
    txe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && ev_tx_load && !ev_tx_empty && !(st_wr && st_bits[0])) |=> !flags_o[B_TXE]);
    // R3
    txreq_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && !no_stretch && !ev_tx_req && !flags_o[B_TXREQ]) |=> !flags_o[B_TXREQ]);
    // R9
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && bus_start) |=> flags_o[B_BUSY]);
    // R6
    nack_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && ev_nack) |=> flags_o[B_NACK]);
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_sts_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int CODE_W   = 7,
    parameter bit SMBUS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              no_stretch,
    input  logic              reload,
    input  logic              auto_end,
    input  logic              host_mode,
    input  logic              alert_en,
    input  logic              alert_n,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_req,
    input  logic              ev_tx_load,
    input  logic              ev_rx_full,
    input  logic              ev_rx_read,
    input  logic              ev_addr_match,
    input  logic              addr_dir,
    input  logic [CODE_W-1:0] addr_code,
    input  logic              ev_nack,
    input  logic              ev_stop,
    input  logic              ev_count_done,
    input  logic              ev_bus_err,
    input  logic              ev_arb_lost,
    input  logic              ev_overrun,
    input  logic              ev_pec_err,
    input  logic              ev_timeout,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sw_start_stop,
    input  logic              sw_count_nz,
    input  logic              clr_wr,
    input  logic [REG_W-1:0]  clr_data,
    input  logic              st_wr,
    input  logic [REG_W-1:0]  st_data,
    output logic [REG_W-1:0]  status
);
    localparam int PAD_W = REG_W - FLAG_W - 1 - CODE_W;

    logic              alert_fall;
    logic [FLAG_W-1:0] flags;
    logic              dir;
    logic [CODE_W-1:0] code;
    logic              unused_bits;

    assign unused_bits = ^{clr_data[REG_W-1:FLAG_W], st_data[REG_W-1:2]};

    i2c_alert_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .alert_n (alert_n),
        .fall_o  (alert_fall)
    );

    i2c_flag_bank #(.SMBUS_EN(SMBUS_EN)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .periph_en     (periph_en),
        .no_stretch    (no_stretch),
        .reload        (reload),
        .auto_end      (auto_end),
        .host_mode     (host_mode),
        .alert_en      (alert_en),
        .alert_fall    (alert_fall),
        .ev_tx_empty   (ev_tx_empty),
        .ev_tx_req     (ev_tx_req),
        .ev_tx_load    (ev_tx_load),
        .ev_rx_full    (ev_rx_full),
        .ev_rx_read    (ev_rx_read),
        .ev_addr_match (ev_addr_match),
        .ev_nack       (ev_nack),
        .ev_stop       (ev_stop),
        .ev_count_done (ev_count_done),
        .ev_bus_err    (ev_bus_err),
        .ev_arb_lost   (ev_arb_lost),
        .ev_overrun    (ev_overrun),
        .ev_pec_err    (ev_pec_err),
        .ev_timeout    (ev_timeout),
        .bus_start     (bus_start),
        .bus_stop      (bus_stop),
        .sw_start_stop (sw_start_stop),
        .sw_count_nz   (sw_count_nz),
        .clr_wr        (clr_wr),
        .clr_bits      (clr_data[FLAG_W-1:0]),
        .st_wr         (st_wr),
        .st_bits       (st_data[1:0]),
        .flags_o       (flags)
    );

    i2c_addr_capture #(.CODE_W(CODE_W)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .periph_en     (periph_en),
        .ev_addr_match (ev_addr_match),
        .addr_dir      (addr_dir),
        .addr_code     (addr_code),
        .dir_o         (dir),
        .code_o        (code)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign status = {{PAD_W{1'b0}}, code, dir, flags};
        end else begin : g_nopad
            assign status = {code, dir, flags};
        end
    endgenerate

    // R13
    smb_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!SMBUS_EN && $past(periph_en)) |-> (status[13:11] == 3'b000));
endmodule

// File: tb/sim_i2c_irq_status.sv
module sim_i2c_irq_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic periph_en, no_stretch, reload, auto_end, host_mode, alert_en, alert_n;
    logic ev_tx_empty, ev_tx_req, ev_tx_load, ev_rx_full, ev_rx_read;
    logic ev_addr_match, addr_dir;
    logic [6:0] addr_code;
    logic ev_nack, ev_stop, ev_count_done, ev_bus_err, ev_arb_lost, ev_overrun;
    logic ev_pec_err, ev_timeout, bus_start, bus_stop, sw_start_stop, sw_count_nz;
    logic clr_wr, st_wr;
    logic [31:0] clr_data, st_data, status0, status1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic [31:0] e;

    i2c_irq_status #(.SMBUS_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .no_stretch(no_stretch),
        .reload(reload), .auto_end(auto_end), .host_mode(host_mode), .alert_en(alert_en),
        .alert_n(alert_n), .ev_tx_empty(ev_tx_empty), .ev_tx_req(ev_tx_req),
        .ev_tx_load(ev_tx_load), .ev_rx_full(ev_rx_full), .ev_rx_read(ev_rx_read),
        .ev_addr_match(ev_addr_match), .addr_dir(addr_dir), .addr_code(addr_code),
        .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_count_done(ev_count_done),
        .ev_bus_err(ev_bus_err), .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun),
        .ev_pec_err(ev_pec_err), .ev_timeout(ev_timeout), .bus_start(bus_start),
        .bus_stop(bus_stop), .sw_start_stop(sw_start_stop), .sw_count_nz(sw_count_nz),
        .clr_wr(clr_wr), .clr_data(clr_data), .st_wr(st_wr), .st_data(st_data),
        .status(status0));

    i2c_irq_status #(.SMBUS_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .no_stretch(no_stretch),
        .reload(reload), .auto_end(auto_end), .host_mode(host_mode), .alert_en(alert_en),
        .alert_n(alert_n), .ev_tx_empty(ev_tx_empty), .ev_tx_req(ev_tx_req),
        .ev_tx_load(ev_tx_load), .ev_rx_full(ev_rx_full), .ev_rx_read(ev_rx_read),
        .ev_addr_match(ev_addr_match), .addr_dir(addr_dir), .addr_code(addr_code),
        .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_count_done(ev_count_done),
        .ev_bus_err(ev_bus_err), .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun),
        .ev_pec_err(ev_pec_err), .ev_timeout(ev_timeout), .bus_start(bus_start),
        .bus_stop(bus_stop), .sw_start_stop(sw_start_stop), .sw_count_nz(sw_count_nz),
        .clr_wr(clr_wr), .clr_data(clr_data), .st_wr(st_wr), .st_data(st_data),
        .status(status1));

    task automatic strobes_off();
        ev_tx_empty = 0; ev_tx_req = 0; ev_tx_load = 0; ev_rx_full = 0; ev_rx_read = 0;
        ev_addr_match = 0; ev_nack = 0; ev_stop = 0; ev_count_done = 0;
        ev_bus_err = 0; ev_arb_lost = 0; ev_overrun = 0; ev_pec_err = 0; ev_timeout = 0;
        bus_start = 0; bus_stop = 0; sw_start_stop = 0; sw_count_nz = 0;
        clr_wr = 0; st_wr = 0; clr_data = '0; st_data = '0;
    endtask

    // driver: inputs already set at a falling edge; one rising edge, then expect
    task automatic step(input logic [31:0] expv, input string tag);
        @(posedge clk);
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        strobes_off();
    endtask

    // monitor: compares both instances away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [31:0] x0, x1;
                string t;
                x0 = exp_q.pop_front();
                t  = tag_q.pop_front();
                x1 = x0 & ~32'h0000_3800;
                checks++;
                if (status0 !== x0 || status1 !== x1) begin
                    errors++;
                    $display("FAIL %s u0=%h exp %h  u1=%h exp %h", t, status0, x0, status1, x1);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        strobes_off();
        periph_en = 1; no_stretch = 0; reload = 0; auto_end = 0;
        host_mode = 0; alert_en = 0; alert_n = 1; addr_dir = 0; addr_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e = 32'h0000_0001;
        step(e, "R1 reset value");

        // R2 transmit-empty
        ev_tx_load = 1;                         e = 32'h0;   step(e, "R2 clear on load");
        st_wr = 1; st_data = 32'h1;             e = 32'h1;   step(e, "R2 flush write");
        ev_tx_load = 1; ev_tx_empty = 1;        e = 32'h1;   step(e, "R2 set wins");
        ev_tx_load = 1;                         e = 32'h0;   step(e, "R2 clear again");

        // R3 transmit-request
        st_wr = 1; st_data = 32'h2;             e = 32'h0;   step(e, "R3 write ignored stretch");
        no_stretch = 1; st_wr = 1; st_data = 32'h2; e = 32'h2; step(e, "R3 write no-stretch");
        ev_tx_load = 1;                         e = 32'h0;   step(e, "R3 clear on load");
        ev_tx_req = 1;                          e = 32'h2;   step(e, "R3 strobe set");
        ev_tx_load = 1;                         e = 32'h0;   step(e, "R3 clear");
        no_stretch = 0;

        // R4 receive-not-empty
        ev_rx_full = 1;                         e = 32'h4;   step(e, "R4 set");
        ev_rx_read = 1;                         e = 32'h0;   step(e, "R4 clear");

        // R5 address capture
        ev_addr_match = 1; addr_dir = 1; addr_code = 7'h5A; e = 32'h00B5_0008; step(e, "R5 capture");
        addr_dir = 0; addr_code = 7'h11;        step(e, "R5 hold no match");
        clr_wr = 1; clr_data = 32'h8;           e = 32'h00B5_0000; step(e, "R5 clear");

        // R6 / R11 error flags
        ev_nack = 1; ev_stop = 1; ev_bus_err = 1; ev_arb_lost = 1; ev_overrun = 1;
        ev_pec_err = 1; ev_timeout = 1;         e = 32'h00B5_1F30; step(e, "R6 R11 set");
        clr_wr = 1; clr_data = 32'h1F30; ev_nack = 1; e = 32'h00B5_0010; step(e, "R6 set beats clear");
        clr_wr = 1; clr_data = 32'h10;          e = 32'h00B5_0000; step(e, "R6 clear");

        // R7 transfer-complete
        ev_count_done = 1;                      e = 32'h00B5_0040; step(e, "R7 set");
        sw_start_stop = 1;                      e = 32'h00B5_0000; step(e, "R7 clear");
        auto_end = 1; ev_count_done = 1;        step(e, "R7 no set auto-end");
        auto_end = 0;

        // R8 transfer-complete-reload
        reload = 1; ev_count_done = 1;          e = 32'h00B5_0080; step(e, "R8 set");
        sw_count_nz = 1;                        e = 32'h00B5_0000; step(e, "R8 clear");
        reload = 0;

        // R9 busy
        bus_start = 1;                          e = 32'h00B5_8000; step(e, "R9 set");
        bus_stop = 1;                           e = 32'h00B5_0000; step(e, "R9 clear");

        // R12 alert
        host_mode = 1; alert_n = 0;             step(e, "R12 disabled edge");
        alert_n = 1;                            step(e, "R12 line high");
        alert_en = 1; alert_n = 0;              e = 32'h00B5_2000; step(e, "R12 set R13 masked");
        clr_wr = 1; clr_data = 32'h2000;        e = 32'h00B5_0000; step(e, "R12 clear held low");
        step(e, "R12 no re-set");
        alert_n = 1;

        // R14 ignored positions
        bus_start = 1;                          e = 32'h00B5_8000; step(e, "R14 prep busy");
        clr_wr = 1; clr_data = 32'hFFFF_C0C7;   step(e, "R14 clear ignored");
        st_wr = 1; st_data = 32'hFFFF_FFFC;     step(e, "R14 write ignored");

        // R10 disable
        ev_rx_full = 1; ev_nack = 1;            e = 32'h00B5_8014; step(e, "R10 prep");
        periph_en = 0;                          e = 32'h00B5_0001; step(e, "R10 wipe");
        ev_nack = 1; ev_addr_match = 1; addr_code = 7'h22; ev_tx_load = 1; step(e, "R10 ignored");
        periph_en = 1;                          step(e, "R10 re-enable");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule